// File: doc/BRIEF.md
# Frequency-Domain Visible Logo Blender

This block mixes a broadcaster's logo into video in the transform domain, one 8×8 block at a time. It takes the host luma DCT coefficients on one stream and the logo DCT coefficients for the same block position on a second stream. Both streams use the same scan order. Each luma output coefficient is a fixed weighted sum: 230/256 of the host coefficient plus 26/256 of the logo coefficient. Weights near 0.9 and 0.1 leave the picture intact and make the logo faintly visible. The block is used between a forward transform and an inverse transform, and it processes intra and predicted frames alike.

Each host coefficient carries a plane flag. Chroma coefficients pass through unchanged with the same single-cycle latency and draw nothing from the logo stream. The logo stream carries only luma blocks, 64 coefficients each, and repeats every frame. An internal block index counts logo blocks, wraps once per frame, and advances a frame counter. The block-start markers of each host/logo pair are compared, and any disagreement latches an error flag.

Top module: `wm_embedder`

## Requirements
- R1: For a luma coefficient pair (host C, logo W), the output is floor((230·C + 26·W + 128) / 256), clamped to the signed 12-bit range [-2048, 2047]. An exact half therefore rounds upward.
- R2: A host coefficient with `hostLuma` = 0 (chroma) is output bit-for-bit unchanged. `logoReady` stays low for it, so no logo coefficient is used.
- R3: A luma transfer takes place only in a cycle where both `hostValid` and `logoValid` are high. While the logo stream is empty, `hostReady` stays low for a luma coefficient and nothing is produced.
- R4: Every accepted coefficient appears on the output one clock later with `outValid` high. `outSob` and `outLuma` carry the host's marker and plane flag.
- R5: While `outValid` is high and `outReady` is low, `outData`, `outSob` and `outLuma` hold steady and no input is taken.
- R6: If `hostSob` differs from `logoSob` on an accepted luma pair, `errFlag` goes high and stays high until reset.
- R7: After every 64 accepted luma pairs, `blockIdx` advances by one. It wraps from BLOCKS−1 to 0, and on that wrap `frameCnt` increments. Chroma transfers move neither counter.
- R8: After reset, `outValid`, `errFlag`, `blockIdx` and `frameCnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host coefficient valid |
| hostReady | output | 1 | Host coefficient accepted this cycle when valid |
| hostData | input | 12 | Host DCT coefficient, signed |
| hostSob | input | 1 | Host block-start marker |
| hostLuma | input | 1 | 1 = luma coefficient, 0 = chroma |
| logoValid | input | 1 | Logo coefficient valid |
| logoReady | output | 1 | Logo coefficient accepted this cycle when valid |
| logoData | input | 12 | Logo DCT coefficient, signed |
| logoSob | input | 1 | Logo block-start marker |
| outValid | output | 1 | Output coefficient valid |
| outReady | input | 1 | Downstream can accept |
| outData | output | 12 | Blended or passed-through coefficient, signed |
| outSob | output | 1 | Block-start marker of the output coefficient |
| outLuma | output | 1 | Plane flag of the output coefficient |
| blockIdx | output | BIW | Current logo block index within the frame |
| frameCnt | output | FRAME_W | Count of completed logo frames |
| errFlag | output | 1 | Sticky block-start mismatch flag |

## Verification
The assertions assume that sources follow valid/ready rules. In particular, a luma coefficient on the host stream waits for the logo stream and does not vanish. They also assume that logo and host blocks arrive aligned, so a marker mismatch is a real error. The bench drives each coefficient at a falling edge and keeps it until the rising edge that transfers it. It presents the logo stream only alongside luma host data, and it starts every 64-pair group with matching markers on both streams, except in the one scenario that deliberately breaks alignment.

// File: rtl/wm_pkg.sv
package wm_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new coefficient into the output stage
    logic blend;  // apply the weighted sum (luma) instead of bypass
  } wm_strobe_t;
endpackage

// File: rtl/wm_ctrl.sv
module wm_ctrl
  import wm_pkg::*;
#(
  parameter int COEFS   = 64,
  parameter int BLOCKS  = 1350,
  parameter int FRAME_W = 16,
  localparam int CW     = $clog2(COEFS),
  localparam int BIW    = $clog2(BLOCKS > 1 ? BLOCKS : 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostValid,
  input  logic               hostLuma,
  input  logic               hostSob,
  input  logic               logoValid,
  input  logic               logoSob,
  input  logic               outValid,
  input  logic               outReady,
  output logic               hostReady,
  output logic               logoReady,
  output wm_strobe_t         strobe,
  output logic [BIW-1:0]     blockIdx,
  output logic [FRAME_W-1:0] frameCnt,
  output logic               errFlag
);
  logic          canAccept;
  logic          lumaFire;
  logic          chromaFire;
  logic          lastCoef;
  logic          lastBlock;
  logic [CW-1:0] coefIdx;

  assign canAccept  = !outValid || outReady;
  assign lumaFire   = canAccept && hostValid && hostLuma && logoValid;
  assign chromaFire = canAccept && hostValid && !hostLuma;

  assign hostReady  = canAccept && (hostLuma ? logoValid : 1'b1);
  assign logoReady  = canAccept && hostValid && hostLuma;

  assign strobe.load  = lumaFire || chromaFire;
  assign strobe.blend = lumaFire;

  assign lastCoef  = (coefIdx == CW'(COEFS - 1));
  assign lastBlock = (blockIdx == BIW'(BLOCKS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coefIdx  <= '0;
      blockIdx <= '0;
      frameCnt <= '0;
    end else if (lumaFire) begin
      coefIdx <= lastCoef ? '0 : coefIdx + 1'b1;
      if (lastCoef) begin
        if (lastBlock) begin
          blockIdx <= '0;
          frameCnt <= frameCnt + 1'b1;
        end else begin
          blockIdx <= blockIdx + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                               errFlag <= 1'b0;
    else if (lumaFire && hostSob != logoSob) errFlag <= 1'b1;
  end
endmodule

// File: rtl/wm_datapath.sv
module wm_datapath
  import wm_pkg::*;
#(
  parameter int DW      = 12,
  parameter int FRAC    = 8,
  parameter int ALPHA_Q = 230,
  parameter int BETA_Q  = 26,
  localparam int PW     = 2 * DW + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wm_strobe_t           strobe,
  input  logic signed [DW-1:0] hostData,
  input  logic signed [DW-1:0] logoData,
  input  logic                 hostSob,
  input  logic                 hostLuma,
  input  logic                 outReady,
  output logic                 outValid,
  output logic signed [DW-1:0] outData,
  output logic                 outSob,
  output logic                 outLuma
);
  localparam logic signed [PW-1:0] ALPHA_S = PW'(ALPHA_Q);
  localparam logic signed [PW-1:0] BETA_S  = PW'(BETA_Q);
  localparam logic signed [PW-1:0] HALF_S  = PW'(1 << (FRAC - 1));
  localparam logic signed [PW-1:0] MAX_S   = PW'((1 << (DW - 1)) - 1);
  localparam logic signed [PW-1:0] MIN_S   = -PW'(1 << (DW - 1));

  logic signed [PW-1:0] hostExt, logoExt, weighted, rounded;
  logic signed [DW-1:0] blended, nextData;

  assign hostExt  = PW'(hostData);
  assign logoExt  = PW'(logoData);
  assign weighted = hostExt * ALPHA_S + logoExt * BETA_S;
  assign rounded  = (weighted + HALF_S) >>> FRAC;

  always_comb begin
    if (rounded > MAX_S)      blended = MAX_S[DW-1:0];
    else if (rounded < MIN_S) blended = MIN_S[DW-1:0];
    else                      blended = rounded[DW-1:0];
  end

  assign nextData = strobe.blend ? blended : hostData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outSob   <= 1'b0;
      outLuma  <= 1'b0;
    end else if (strobe.load) begin
      outValid <= 1'b1;
      outData  <= nextData;
      outSob   <= hostSob;
      outLuma  <= hostLuma;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/wm_embedder.sv
module wm_embedder
  import wm_pkg::*;
#(
  parameter int DW      = 12,
  parameter int BLK_DIM = 8,
  parameter int BLOCKS  = 1350,
  parameter int FRAME_W = 16,
  parameter int FRAC    = 8,
  parameter int ALPHA_Q = 230,
  parameter int BETA_Q  = 26,
  localparam int COEFS  = BLK_DIM * BLK_DIM,
  localparam int BIW    = $clog2(BLOCKS > 1 ? BLOCKS : 2)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostValid,
  output logic                 hostReady,
  input  logic signed [DW-1:0] hostData,
  input  logic                 hostSob,
  input  logic                 hostLuma,
  input  logic                 logoValid,
  output logic                 logoReady,
  input  logic signed [DW-1:0] logoData,
  input  logic                 logoSob,
  output logic                 outValid,
  input  logic                 outReady,
  output logic signed [DW-1:0] outData,
  output logic                 outSob,
  output logic                 outLuma,
  output logic [BIW-1:0]       blockIdx,
  output logic [FRAME_W-1:0]   frameCnt,
  output logic                 errFlag
);
  wm_strobe_t strobe;

  wm_ctrl #(.COEFS(COEFS), .BLOCKS(BLOCKS), .FRAME_W(FRAME_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostValid(hostValid), .hostLuma(hostLuma), .hostSob(hostSob),
    .logoValid(logoValid), .logoSob(logoSob),
    .outValid(outValid), .outReady(outReady),
    .hostReady(hostReady), .logoReady(logoReady), .strobe(strobe),
    .blockIdx(blockIdx), .frameCnt(frameCnt), .errFlag(errFlag)
  );

  wm_datapath #(.DW(DW), .FRAC(FRAC), .ALPHA_Q(ALPHA_Q), .BETA_Q(BETA_Q)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hostData(hostData), .logoData(logoData),
    .hostSob(hostSob), .hostLuma(hostLuma), .outReady(outReady),
    .outValid(outValid), .outData(outData), .outSob(outSob), .outLuma(outLuma)
  );
endmodule

// File: rtl/wm_embedder_sva.sv
module wm_embedder_sva #(
  parameter int DW      = 12,
  parameter int BLOCKS  = 1350,
  parameter int FRAME_W = 16,
  localparam int BIW    = $clog2(BLOCKS > 1 ? BLOCKS : 2)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 hostValid,
  input logic                 hostReady,
  input logic signed [DW-1:0] hostData,
  input logic                 hostSob,
  input logic                 hostLuma,
  input logic                 logoValid,
  input logic                 logoReady,
  input logic signed [DW-1:0] logoData,
  input logic                 logoSob,
  input logic                 outValid,
  input logic                 outReady,
  input logic signed [DW-1:0] outData,
  input logic                 outSob,
  input logic                 outLuma,
  input logic [BIW-1:0]       blockIdx,
  input logic [FRAME_W-1:0]   frameCnt,
  input logic                 errFlag
);
  a_r2_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && hostReady && !hostLuma) |=> (outData == $past(hostData) && !outLuma));

  a_r2_logo_idle: assert property (@(posedge clk) disable iff (!rstN)
    !(hostValid && hostLuma) |-> !logoReady);

  a_r3_wait_logo: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && hostLuma && !logoValid) |-> !hostReady);

  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && hostReady) |=> (outValid && outSob == $past(hostSob)));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outSob) && $stable(outLuma)));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  a_r6_detect: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && hostReady && hostLuma && hostSob != logoSob) |=> errFlag);

  a_r7_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    blockIdx <= BIW'(BLOCKS - 1));

  a_r7_chroma_still: assert property (@(posedge clk) disable iff (!rstN)
    !(hostValid && hostReady && hostLuma) |=> ($stable(blockIdx) && $stable(frameCnt)));
endmodule

bind wm_embedder wm_embedder_sva #(.DW(DW), .BLOCKS(BLOCKS), .FRAME_W(FRAME_W)) u_sva (.*);

// File: tb/wm_embedder_test.sv
`timescale 1ns/1ps
module wm_embedder_test;
  localparam int DW = 12;
  localparam int BLOCKS = 3;
  localparam int FRAME_W = 16;
  localparam int BIW = $clog2(BLOCKS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostValid = 1'b0, hostSob = 1'b0, hostLuma = 1'b0;
  logic logoValid = 1'b0, logoSob = 1'b0;
  logic signed [DW-1:0] hostData = '0, logoData = '0;
  logic outReady = 1'b1;
  logic hostReady, logoReady, outValid, outSob, outLuma, errFlag;
  logic signed [DW-1:0] outData;
  logic [BIW-1:0] blockIdx;
  logic [FRAME_W-1:0] frameCnt;

  int checks = 0;
  int errors = 0;
  int lumaSent = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wm_embedder #(.DW(DW), .BLOCKS(BLOCKS), .FRAME_W(FRAME_W)) uut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int blendRef(input int c, input int w);
    int v;
    v = (230 * c + 26 * w + 128) >>> 8;
    if (v > 2047) v = 2047;
    if (v < -2048) v = -2048;
    return v;
  endfunction

  // one transfer with outReady high; checks output one cycle later
  task automatic xfer(input int c, input int w, input logic sob, input logic luma);
    @(negedge clk);
    hostValid = 1'b1; hostData = DW'(c); hostSob = sob; hostLuma = luma;
    logoValid = luma; logoData = DW'(w); logoSob = sob;
    #1;
    if (!luma) check("R2 logoReady low on chroma", int'(logoReady), 0);
    @(negedge clk);
    hostValid = 1'b0; logoValid = 1'b0;
    check("R4 outValid", int'(outValid), 1);
    check("R4 outSob", int'(outSob), int'(sob));
    if (luma) begin
      check("R1 blend value", int'(outData), blendRef(c, w));
      lumaSent++;
    end else begin
      check("R2 chroma passthrough", int'(outData), c);
    end
  endtask

  task automatic checkCounters(input string req);
    check({req, " blockIdx"}, int'(blockIdx), (lumaSent / 64) % BLOCKS);
    check({req, " frameCnt"}, int'(frameCnt), (lumaSent / 64) / BLOCKS);
  endtask

  task automatic testReset();
    check("R8 outValid", int'(outValid), 0);
    check("R8 errFlag", int'(errFlag), 0);
    check("R8 blockIdx", int'(blockIdx), 0);
    check("R8 frameCnt", int'(frameCnt), 0);
  endtask

  task automatic testBlend();
    xfer(0, 0, 1'b1, 1'b1);
    xfer(100, 50, 1'b0, 1'b1);
    xfer(1, 65, 1'b0, 1'b1);       // exact half -> 8 (R1)
    xfer(-1, -65, 1'b0, 1'b1);     // exact half -> -7 (R1)
    xfer(2047, 2047, 1'b0, 1'b1);
    xfer(-2048, -2048, 1'b0, 1'b1);
    xfer(-2048, 2047, 1'b0, 1'b1);
    xfer(1000, -1500, 1'b0, 1'b1);
  endtask

  task automatic testChroma();
    xfer(-777, 0, 1'b1, 1'b0);
    xfer(2047, 0, 1'b0, 1'b0);
    checkCounters("R7 chroma leaves counters");
  endtask

  task automatic testWaitLogo();
    @(negedge clk);
    hostValid = 1'b1; hostData = 12'sd300; hostLuma = 1'b1; hostSob = 1'b0;
    logoValid = 1'b0; logoData = 12'sd40; logoSob = 1'b0;
    #1 check("R3 hostReady low without logo", int'(hostReady), 0);
    repeat (3) @(negedge clk);
    check("R3 nothing produced", int'(outValid), 0);
    logoValid = 1'b1;
    @(negedge clk);
    hostValid = 1'b0; logoValid = 1'b0;
    check("R3 output once paired", int'(outValid), 1);
    check("R3 value", int'(outData), blendRef(300, 40));
    lumaSent++;
  endtask

  task automatic testBackpressure();
    int held;
    @(negedge clk);
    outReady = 1'b0;
    hostValid = 1'b1; hostData = -12'sd5; hostLuma = 1'b0; hostSob = 1'b0;
    logoValid = 1'b0;
    @(negedge clk);
    held = int'(outData);
    check("R5 first result", held, -5);
    hostData = 12'sd99;
    for (int k = 0; k < 3; k++) begin
      #1 check("R5 hostReady low when stalled", int'(hostReady), 0);
      @(negedge clk);
      check("R5 outValid held", int'(outValid), 1);
      check("R5 outData held", int'(outData), held);
    end
    outReady = 1'b1;
    @(negedge clk);
    hostValid = 1'b0;
    check("R5 second after release", int'(outData), 99);
  endtask

  task automatic testCounters();
    checkCounters("R7 start");
    while (lumaSent % 64 != 0) xfer(lumaSent, 3, 1'b0, 1'b1);
    checkCounters("R7 aligned");
    for (int b = 0; b < BLOCKS + 1; b++) begin
      for (int k = 0; k < 64; k++) xfer(k * 7 - 200, 20 - k, k == 0, 1'b1);
      checkCounters("R7 block end");
    end
    check("R7 frame wrapped", int'(frameCnt) >= 1, 1);
  endtask

  task automatic testMismatch();
    check("R6 clear before", int'(errFlag), 0);
    @(negedge clk);
    hostValid = 1'b1; hostData = 12'sd10; hostLuma = 1'b1; hostSob = 1'b1;
    logoValid = 1'b1; logoData = 12'sd10; logoSob = 1'b0;
    @(negedge clk);
    hostValid = 1'b0; logoValid = 1'b0;
    lumaSent++;
    check("R6 flag set", int'(errFlag), 1);
    xfer(5, 5, 1'b0, 1'b1);
    xfer(5, 5, 1'b0, 1'b1);
    check("R6 flag sticky", int'(errFlag), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBlend();
    testChroma();
    testWaitLogo();
    testBackpressure();
    testCounters();
    testMismatch();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule